// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer with a small register file on a synchronous 16-bit read/write bus with two byte lanes. Software programs a timeout in ticks and restarts the countdown by writing to a reload register. Reading that same register returns the live count. A tick-enable input advances the countdown by one step. In a system it would pulse once about every 0.6 s, so a timeout of S seconds is about S*10/6 ticks.

When the count runs out, the first expiry raises a timeout flag and the counter starts again from the programmed value. A second expiry with no reload write in between escalates. It raises a second-timeout flag and a boot-status flag, and it pulses a reboot request unless the no-reboot strap is high. A halt bit freezes the countdown. A lock bit, once set, stays set until reset. Writes to a pair of data bytes raise software-event status bits. Status bits are split over two registers and are cleared by writing one to them.

Top module: `wdog_twostage`

## Requirements
- R1: After reset, the registers read as follows: timer value (address 1) = 0x0004, auxiliary control (address 6) = 0x0008, interrupt-select (address 7) = 0x0003. Count (address 0), data (address 2), status A (address 3), status B (address 4) and main control (address 5) read 0x0000.
- R2: Any write to address 0 loads the counter from the timer value, whatever the byte enables or data. It also forgets any earlier expiry, so the next expiry counts as a first one.
- R3: While bit 0 (halt) of main control is 1, ticks leave the count unchanged. Once the bit is cleared, each tick decrements the count again.
- R4: A read of address 0 returns the count zero-extended. Each cycle with tick_en high and halt clear lowers it by exactly one, as long as it is above 1.
- R5: A tick that arrives while the count is 1 or 0 is an expiry. It sets bit 3 of status A and reloads the counter from the timer value. The timer value is masked to CNT_W bits. With 0xFFFF written and CNT_W=10, the count reads 1 after 1022 ticks with bit 3 still clear, and bit 3 sets on the 1023rd tick.
- R6: An expiry that follows an earlier expiry with no address-0 write in between sets bit 1 (second timeout) and bit 2 (boot status) of status B. This holds even if bit 3 of status A was cleared in between.
- R7: reboot_req is a one-cycle pulse, raised in the cycle after a second expiry when no_reboot is low and status B bit 1 was clear. There is no pulse while no_reboot is high, and no further pulse while status B bit 1 stays set.
- R8: Status bits clear only where a 1 is written in an enabled byte lane (bus_be[0] covers bits 7:0, bus_be[1] covers bits 15:8). Writing back a value just read leaves the register at zero.
- R9: Bit 1 (lock) of main control, once written as 1, reads 1 until reset whatever is written later.
- R10: A write to address 2 stores the low lane as the data-in byte and sets status A bit 1. It stores the high lane as the data-out byte and sets status A bit 2. Address 2 reads {data-out, data-in}.
- R11: Writes to the timer value, auxiliary control and interrupt-select registers change only the enabled byte lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 3 | Register address |
| bus_be | input | 2 | Byte enables, bit 0 covers data bits 7:0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| tick_en | input | 1 | One countdown step per cycle it is high |
| no_reboot | input | 1 | Strap that suppresses the reboot request |
| reboot_req | output | 1 | One-cycle reboot request pulse |

## Verification
Some properties are checked by assertions on every cycle. These are: a single decrement per running tick, a frozen count while halted, a lock bit that never falls, a reboot pulse that lasts one cycle and never appears with the strap high, and boot status rising together with the second-timeout flag. Other behaviour can only be shown by the bench's scenarios. That covers the exact tick on which each expiry lands across a sweep of timeout values and the masked all-ones value. It also covers reload writes forgetting an earlier expiry, write-one-to-clear per byte lane, and the single pulse per uncleared second timeout.

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int CNT_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        tick_en,
  input  logic        no_reboot,
  output logic        reboot_req
);

  localparam logic [2:0] A_CNT = 3'd0, A_TMR = 3'd1, A_DAT = 3'd2, A_STA = 3'd3,
                         A_STB = 3'd4, A_CT1 = 3'd5, A_CT2 = 3'd6, A_IRQ = 3'd7;
  localparam logic [CNT_W-1:0] TMR_RST = CNT_W'(4);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] tmr, count;
  logic             armed, halt, lock;
  logic [15:0]      ctl2;
  logic [7:0]       irq_sel, din, dout;
  logic             st_din, st_dout, st_to, st_sec, st_boot;

  wire        wr    = bus_sel & bus_we;
  wire [15:0] lanes = {{8{bus_be[1]}}, {8{bus_be[0]}}};
  wire [15:0] clr   = bus_wdata & lanes;
  wire        w_cnt = wr && bus_addr == A_CNT;
  wire        w_dat = wr && bus_addr == A_DAT;
  wire        w_sta = wr && bus_addr == A_STA;
  wire        w_stb = wr && bus_addr == A_STB;
  wire        step  = tick_en & ~halt;
  wire        expire = step & ~w_cnt & (count <= ONE);
  wire        second = expire & armed;

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                        input logic [15:0] m);
    return (old & ~m) | (nw & m);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count <= '0;
      armed <= 1'b0;
    end else if (w_cnt) begin
      count <= tmr;
      armed <= 1'b0;
    end else if (expire) begin
      count <= tmr;
      armed <= 1'b1;
    end else if (step) begin
      count <= count - ONE;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmr     <= TMR_RST;
      ctl2    <= 16'h0008;
      irq_sel <= 8'h03;
      halt    <= 1'b0;
      lock    <= 1'b0;
      din     <= '0;
      dout    <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_TMR: tmr <= CNT_W'(merge(16'(tmr), bus_wdata, lanes));
        A_CT2: ctl2 <= merge(ctl2, bus_wdata, lanes);
        A_IRQ: if (bus_be[0]) irq_sel <= bus_wdata[7:0];
        A_CT1: if (bus_be[0]) begin
          halt <= bus_wdata[0];
          lock <= lock | bus_wdata[1];
        end
        A_DAT: begin
          if (bus_be[0]) din  <= bus_wdata[7:0];
          if (bus_be[1]) dout <= bus_wdata[15:8];
        end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_din     <= 1'b0;
      st_dout    <= 1'b0;
      st_to      <= 1'b0;
      st_sec     <= 1'b0;
      st_boot    <= 1'b0;
      reboot_req <= 1'b0;
    end else begin
      st_din     <= (st_din  & ~(w_sta & clr[1])) | (w_dat & bus_be[0]);
      st_dout    <= (st_dout & ~(w_sta & clr[2])) | (w_dat & bus_be[1]);
      st_to      <= (st_to   & ~(w_sta & clr[3])) | expire;
      st_sec     <= (st_sec  & ~(w_stb & clr[1])) | second;
      st_boot    <= (st_boot & ~(w_stb & clr[2])) | second;
      reboot_req <= second & ~no_reboot & ~st_sec;
    end

  always_comb
    case (bus_addr)
      A_CNT:   bus_rdata = 16'(count);
      A_TMR:   bus_rdata = 16'(tmr);
      A_DAT:   bus_rdata = {dout, din};
      A_STA:   bus_rdata = {12'd0, st_to, st_dout, st_din, 1'b0};
      A_STB:   bus_rdata = {13'd0, st_boot, st_sec, 1'b0};
      A_CT1:   bus_rdata = {14'd0, lock, halt};
      A_CT2:   bus_rdata = ctl2;
      default: bus_rdata = {8'd0, irq_sel};
    endcase

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !w_cnt && count > ONE) |=> count == $past(count) - ONE);
  p_halt_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !w_cnt) |=> $stable(count));
  p_lock_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  p_pulse_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |=> !reboot_req);
  p_strap_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(no_reboot) |-> !reboot_req);
  p_boot_with_sec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_sec) |-> st_boot);

endmodule

// File: tb/sim_wdog_twostage.sv
module sim_wdog_twostage;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0, tick_en = 0, no_reboot = 0;
  logic [2:0] bus_addr = 0;
  logic [1:0] bus_be = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic reboot_req;
  int vecs = 0, bad = 0, pulses = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  wdog_twostage u0 (.clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_be, .bus_wdata,
                    .bus_rdata, .tick_en, .no_reboot, .reboot_req);

  always @(negedge clk) if (reboot_req) pulses++;

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rchk(input string tag, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic tk(input int n);
    repeat (n) begin
      @(negedge clk); tick_en = 1;
      @(negedge clk); tick_en = 0;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rchk("R1 count", 0, 16'h0000);
    rchk("R1 timer", 1, 16'h0004);
    rchk("R1 data", 2, 16'h0000);
    rchk("R1 statA", 3, 16'h0000);
    rchk("R1 statB", 4, 16'h0000);
    rchk("R1 ctrl", 5, 16'h0000);
    rchk("R1 aux", 6, 16'h0008);
    rchk("R1 irqsel", 7, 16'h0003);

    wr(6, 16'hA5C3, 2'b10);
    rchk("R11 aux high lane", 6, 16'hA508);
    wr(7, 16'h7711, 2'b10);
    rchk("R11 irqsel high lane ignored", 7, 16'h0003);
    wr(7, 16'h7711, 2'b01);
    rchk("R11 irqsel low lane", 7, 16'h0011);
    wr(1, 16'hFFFF, 2'b01);
    rchk("R11 timer low lane", 1, 16'h00FF);

    for (int v = 1; v <= 12; v++) begin
      logic [15:0] s;
      no_reboot = v[0];
      wr(1, 16'(v));
      wr(0, 16'h0000, 2'b00);
      rchk("R2 load", 0, 16'(v));
      p0 = pulses;
      for (int k = 1; k < v; k++) begin
        tk(1);
        rchk("R4 decrement", 0, 16'(v - k));
        rchk("R5 no early expiry", 3, 16'h0000);
      end
      tk(1);
      rchk("R5 first expiry flag", 3, 16'h0008);
      rchk("R5 reload after expiry", 0, 16'(v));
      rchk("R6 no second yet", 4, 16'h0000);
      wr(3, 16'h0008, 2'b01);
      rchk("R8 statA cleared", 3, 16'h0000);
      tk(v);
      rchk("R6 second timeout", 4, 16'h0006);
      rchk("R5 flag again", 3, 16'h0008);
      chk("R7 pulse count", 16'(pulses - p0), v[0] ? 16'd0 : 16'd1);
      tk(v);
      chk("R7 no repeat while set", 16'(pulses - p0), v[0] ? 16'd0 : 16'd1);
      rd(4, s);
      wr(4, s);
      rchk("R8 statB write-back", 4, 16'h0000);
      rd(3, s);
      wr(3, s);
      rchk("R8 statA write-back", 3, 16'h0000);
    end

    no_reboot = 0;
    wr(1, 16'd3);
    wr(0, 16'h1234);
    tk(3);
    rchk("R2 first expiry", 3, 16'h0008);
    wr(0, 16'h0000, 2'b10);
    p0 = pulses;
    tk(3);
    rchk("R2 reload forgets expiry", 4, 16'h0000);
    chk("R2 no pulse", 16'(pulses - p0), 16'd0);
    tk(3);
    rchk("R6 after reload two expiries", 4, 16'h0006);
    chk("R7 one pulse", 16'(pulses - p0), 16'd1);
    wr(4, 16'h0006);
    wr(3, 16'h000E);

    wr(1, 16'd9);
    wr(0, 0);
    wr(5, 16'h0001);
    tk(5);
    rchk("R3 halted count", 0, 16'd9);
    wr(5, 16'h0000);
    tk(2);
    rchk("R3 resumed", 0, 16'd7);

    wr(1, 16'hFFFF);
    rchk("R5 masked timer", 1, 16'h03FF);
    wr(0, 0);
    tk(1022);
    rchk("R5 all-ones count at 1", 0, 16'd1);
    rchk("R5 all-ones no flag", 3, 16'h0000);
    tk(1);
    rchk("R5 all-ones expiry", 3, 16'h0008);
    wr(3, 16'h0008);

    wr(2, 16'h5A3C, 2'b01);
    rchk("R10 data-in flag", 3, 16'h0002);
    wr(2, 16'hC300, 2'b10);
    rchk("R10 data-out flag", 3, 16'h0006);
    rchk("R10 data bytes", 2, 16'hC33C);
    wr(3, 16'h0006, 2'b10);
    rchk("R8 disabled lane keeps", 3, 16'h0006);
    wr(3, 16'h0004, 2'b01);
    rchk("R8 only written one clears", 3, 16'h0002);
    wr(3, 16'h0002, 2'b01);
    rchk("R8 cleared", 3, 16'h0000);

    wr(5, 16'h0002);
    wr(5, 16'h0000);
    rchk("R9 lock sticky", 5, 16'h0002);
    wr(5, 16'h0001);
    rchk("R9 lock with halt", 5, 16'h0003);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule